// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt inputs and presents one interrupt line to a processor. Software reaches it through two byte-wide addresses: a command port (`bus_sel_data` = 0) and a data port (`bus_sel_data` = 1). Before first use, software writes a four-step configuration sequence. The sequence sets the vector base, a cascade word and a mode word. After that, software can mask inputs, choose which status register a command-port read returns, and retire in-service levels.

Rising edges on the inputs are latched as pending requests. Priority is fixed: the lowest input number wins. When the processor pulses the acknowledge input, the block moves the winning request into service and returns the vector number one cycle later. In auto end-of-interrupt mode the block does not hold the in-service bit. The stored cascade word is driven out. On a master it lets the system treat chosen inputs as slave requests; on a slave it carries the slave's identity number.

The configuration state machine has five states. `ST_UNCFG` is the state after reset. A command write of 0x11 moves it to `ST_GET_BASE` from any state. A data write then moves it to `ST_GET_CASC`, a second data write to `ST_GET_MODE`, and a third data write to `ST_RUN`. Every other write leaves the state unchanged.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are 0 and a data-port read returns the mask as 0xFF.
- R2: A command write of 0x11 clears the mask, pending and in-service registers. The next three data writes are stored as the vector base, the cascade word (driven on `casc_word`) and the mode word. None of these three writes reaches the mask.
- R3: A rising edge on `irq_in[n]` sets pending bit n in the cycle after it is seen. A level held high does not set the bit again after it has been acknowledged.
- R4: Outside the configuration sequence, data-port writes and reads access the mask, where a 1 bit masks an input. A masked pending request stays visible in the pending readback but cannot raise `int_out`.
- R5: Among unmasked pending inputs the lowest index wins. An acknowledge pulse on `inta` produces `vec_valid` for one cycle in the next cycle, with `vec_out` = base + n.
- R6: `int_out` is 1 only in `ST_RUN`, and only while an unmasked pending input has a lower index than every set in-service bit.
- R7: A command write of 0x0A makes command-port reads return the pending register, and 0x0B makes them return the in-service register. Reads return the pending register after each configuration start.
- R8: A command write of 0x60+n (n = 0..7) clears in-service bit n only.
- R9: When mode-word bit 1 is set, an acknowledge clears the pending bit and leaves the in-service register unchanged.
- R10: An acknowledge with no eligible request returns base + 7 and changes neither the pending nor the in-service register.
- R11: A specific end-of-interrupt and an acknowledge in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel_data | input | 1 | 0 selects the command port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| irq_in | input | 8 | Interrupt request inputs, edge-sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `inta` |
| vec_out | output | 8 | Vector number |
| casc_word | output | 8 | Stored cascade word |

## Verification
An end-of-interrupt write and an acknowledge can land on the same clock edge. One clears an in-service bit while the other sets a different one. The bench provokes this by holding input 6 in service and raising input 2. It then drives the command write 0x66 together with `inta` in a single cycle. It judges the result from two things: the vector 0x22 arriving in the scoreboard, and an in-service readback of exactly 0x04, which shows that neither update was lost.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        ST_UNCFG,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE,
        ST_RUN
    } cfg_state_t;

    localparam logic [DW-1:0] CMD_INIT     = 8'h11;
    localparam logic [DW-1:0] CMD_SEL_PEND = 8'h0A;
    localparam logic [DW-1:0] CMD_SEL_ISR  = 8'h0B;
    localparam logic [4:0]    CMD_EOI_HI   = 5'b01100;
    localparam int            AEOI_BIT     = 1;

    function automatic logic [DW-1:0] lowest_bit(input logic [DW-1:0] v);
        return v & (~v + 1'b1);
    endfunction
endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output cfg_state_t    state,
    output logic [DW-1:0] base,
    output logic [DW-1:0] casc,
    output logic          aeoi,
    output logic [DW-1:0] mask,
    output logic          rd_isr_sel,
    output logic          init_start,
    output logic [DW-1:0] eoi_clr
);
    cfg_state_t state_nx;
    logic       run_cmd;

    assign init_start = cmd_wr && (wdata == CMD_INIT);
    assign run_cmd    = cmd_wr && (state == ST_RUN || state == ST_UNCFG);

    always_comb begin
        eoi_clr = '0;
        if (run_cmd && wdata[7:3] == CMD_EOI_HI)
            eoi_clr[wdata[2:0]] = 1'b1;
    end

    always_comb begin
        state_nx = state;
        if (init_start) begin
            state_nx = ST_GET_BASE;
        end else if (dat_wr) begin
            unique case (state)
                ST_GET_BASE: state_nx = ST_GET_CASC;
                ST_GET_CASC: state_nx = ST_GET_MODE;
                ST_GET_MODE: state_nx = ST_RUN;
                ST_UNCFG,
                ST_RUN:      state_nx = state;
                default:     state_nx = ST_UNCFG;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNCFG;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base       <= '0;
            casc       <= '0;
            aeoi       <= 1'b0;
            mask       <= '1;
            rd_isr_sel <= 1'b0;
        end else if (init_start) begin
            mask       <= '0;
            rd_isr_sel <= 1'b0;
        end else begin
            if (dat_wr) begin
                unique case (state)
                    ST_GET_BASE: base <= wdata;
                    ST_GET_CASC: casc <= wdata;
                    ST_GET_MODE: aeoi <= wdata[AEOI_BIT];
                    ST_UNCFG,
                    ST_RUN:      mask <= wdata;
                    default:     mask <= mask;
                endcase
            end
            if (run_cmd && wdata == CMD_SEL_PEND) rd_isr_sel <= 1'b0;
            if (run_cmd && wdata == CMD_SEL_ISR)  rd_isr_sel <= 1'b1;
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] clr,
    input  logic         flush,
    output logic [N-1:0] pend
);
    logic [N-1:0] irq_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_q[i] <= 1'b0;
                pend[i]  <= 1'b0;
            end else begin
                irq_q[i] <= irq_in[i];
                if (flush)
                    pend[i] <= 1'b0;
                else if (irq_in[i] && !irq_q[i])
                    pend[i] <= 1'b1;
                else if (clr[i])
                    pend[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
    import pic_pkg::*;
(
    input  logic [DW-1:0] pend,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] isr,
    output logic          any,
    output logic [DW-1:0] grant,
    output logic [2:0]    grant_idx
);
    logic [DW-1:0] above, elig;

    assign above = (isr == '0) ? '1 : (lowest_bit(isr) - 1'b1);
    assign elig  = pend & ~mask & above;
    assign any   = |elig;
    assign grant = lowest_bit(elig);

    always_comb begin
        grant_idx = '0;
        for (int i = DW - 1; i >= 0; i--)
            if (grant[i]) grant_idx = 3'(i);
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_sel_data,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] irq_in,
    output logic          int_out,
    input  logic          inta,
    output logic          vec_valid,
    output logic [DW-1:0] vec_out,
    output logic [DW-1:0] casc_word
);
    cfg_state_t    state;
    logic [DW-1:0] base, mask, eoi_clr, pend, grant, isr_q, clr;
    logic          aeoi, rd_isr_sel, init_start, any, run, take;
    logic [2:0]    grant_idx;
    logic          cmd_wr, dat_wr;

    assign cmd_wr = bus_wr && !bus_sel_data;
    assign dat_wr = bus_wr &&  bus_sel_data;

    pic_cfg_seq u_cfg (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
        .wdata(bus_wdata), .state(state), .base(base), .casc(casc_word),
        .aeoi(aeoi), .mask(mask), .rd_isr_sel(rd_isr_sel),
        .init_start(init_start), .eoi_clr(eoi_clr)
    );

    assign run  = (state == ST_RUN);
    assign take = inta && run && any;
    assign clr  = take ? grant : '0;

    pic_req_latch #(.N(DW)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(clr),
        .flush(init_start), .pend(pend)
    );

    pic_prio_pick u_pick (
        .pend(pend), .mask(mask), .isr(isr_q),
        .any(any), .grant(grant), .grant_idx(grant_idx)
    );

    assign int_out = run && any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            isr_q <= '0;
        else if (init_start)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~eoi_clr) | ((take && !aeoi) ? grant : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= inta;
            if (inta)
                vec_out <= base + (take ? DW'(grant_idx) : DW'(7));
        end
    end

    assign bus_rdata = bus_sel_data ? mask : (rd_isr_sel ? isr_q : pend);
endmodule

// File: rtl/pic_checker.sv
module pic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       inta,
    input logic       vec_valid,
    input logic       int_out,
    input logic       run,
    input logic       aeoi,
    input logic       cmd_wr,
    input logic [7:0] wdata,
    input logic [7:0] pend,
    input logic [7:0] mask,
    input logic [7:0] isr
);
    p_vec_follows_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> vec_valid);

    p_vec_only_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> !vec_valid);

    p_int_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (run && (pend & ~mask) != 8'h00));

    p_eoi_clears_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmd_wr && wdata[7:3] == 5'b01100 && !inta) |=> !isr[$past(wdata[2:0])]);

    p_aeoi_keeps_isr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && aeoi) |-> isr == 8'h00);

    p_spurious_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && inta && !int_out && !cmd_wr) |=> $stable(isr));
endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .vec_valid(vec_valid),
    .int_out(int_out), .run(run), .aeoi(aeoi), .cmd_wr(cmd_wr),
    .wdata(bus_wdata), .pend(pend), .mask(mask), .isr(isr_q)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_sel_data = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = '0, irq_in = '0;
    logic [7:0] bus_rdata, vec_out, casc_word;
    logic       int_out, vec_valid;

    int n_tests = 0, n_fail = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_data(bus_sel_data),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .inta(inta), .vec_valid(vec_valid),
        .vec_out(vec_out), .casc_word(casc_word)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected vectors as the design returns them
    always @(negedge clk) begin
        if (vec_valid) begin
            if (exp_q.size() == 0) chk("R5 unexpected vector", vec_out, 8'hxx);
            else chk("R5 vector", vec_out, exp_q.pop_front());
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_sel_data = sel; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk); bus_sel_data = sel; #0.5; d = bus_rdata;
    endtask

    task automatic ack(input logic [7:0] exp_vec);
        exp_q.push_back(exp_vec);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic init_seq(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(1'b0, 8'h11); wr(1'b1, b); wr(1'b1, c); wr(1'b1, m);
    endtask

    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        rd(1'b1, d); chk("R1 mask", d, 8'hFF);
        rst_n = 1'b1;

        // R2 configuration sequence
        init_seq(8'h20, 8'h04, 8'h00);
        chk("R2 cascade word", casc_word, 8'h04);
        rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);
        rd(1'b0, d); chk("R7 default pending read", d, 8'h00);

        // R3/R5 priority between two edges
        set_irq(8'h28);
        chk("R6 int raised", {7'd0, int_out}, 8'h01);
        rd(1'b0, d); chk("R3 pending", d, 8'h28);
        ack(8'h23);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R7 isr read", d, 8'h08);
        chk("R6 lower prio blocked", {7'd0, int_out}, 8'h00);

        // R6 nesting
        set_irq(8'h2A);
        chk("R6 nested raise", {7'd0, int_out}, 8'h01);
        ack(8'h21);
        rd(1'b0, d); chk("R5 isr two levels", d, 8'h0A);

        // R8 specific EOI
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R8 eoi 1", d, 8'h08);
        chk("R8 int after eoi1", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h63);
        rd(1'b0, d); chk("R8 eoi 3", d, 8'h00);
        chk("R8 int after eoi3", {7'd0, int_out}, 8'h01);
        ack(8'h25);
        wr(1'b0, 8'h65);
        chk("R3 level no retrigger", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R3 pending after level", d, 8'h00);
        set_irq(8'h00);

        // R4 masking
        wr(1'b1, 8'h01);
        rd(1'b1, d); chk("R4 mask read", d, 8'h01);
        set_irq(8'h01);
        chk("R4 masked no int", {7'd0, int_out}, 8'h00);
        rd(1'b0, d); chk("R4 masked pending visible", d, 8'h01);
        wr(1'b1, 8'h00);
        chk("R4 unmask int", {7'd0, int_out}, 8'h01);
        ack(8'h20);
        wr(1'b0, 8'h60);
        set_irq(8'h00);

        // R10 spurious
        set_irq(8'h40);
        chk("R10 int before mask", {7'd0, int_out}, 8'h01);
        wr(1'b1, 8'h40);
        ack(8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R10 isr unchanged", d, 8'h00);
        wr(1'b1, 8'h00);
        ack(8'h26);
        rd(1'b0, d); chk("R5 isr input6", d, 8'h40);

        // R11 EOI and acknowledge in the same cycle
        set_irq(8'h44);
        chk("R11 int for input2", {7'd0, int_out}, 8'h01);
        exp_q.push_back(8'h22);
        @(negedge clk); bus_wr = 1'b1; bus_sel_data = 1'b0; bus_wdata = 8'h66; inta = 1'b1;
        @(negedge clk); bus_wr = 1'b0; inta = 1'b0;
        @(negedge clk);
        rd(1'b0, d); chk("R11 isr after both", d, 8'h04);
        wr(1'b0, 8'h62);
        set_irq(8'h00);

        // R9 auto end-of-interrupt after reconfiguration
        init_seq(8'h40, 8'h02, 8'h02);
        chk("R2 cascade slave id", casc_word, 8'h02);
        rd(1'b1, d); chk("R2 data writes skip mask", d, 8'h00);
        rd(1'b0, d); chk("R7 pending after reinit", d, 8'h00);
        set_irq(8'h10);
        ack(8'h44);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R9 isr empty", d, 8'h00);
        chk("R9 int low", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R9 pending cleared", d, 8'h00);

        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule